// File: doc/BRIEF.md
# Givens Rotation Systolic Row

This block is one row of a triangular systolic array that keeps a recursive least-squares problem in QR-updated form. It holds one diagonal element in a pivot cell and one off-diagonal element in each of the rotation cells that follow. Every accepted sample vector annihilates its pivot entry against the stored diagonal and rotates the remaining entries. The rotated leftovers leave the row as the input vector for the next row down. A running product of rotation cosines also leaves the row, for error-signal formation further on.

All arithmetic is real and fixed-point. The pivot cell computes a cosine and sine from the forgotten diagonal and the incoming pivot sample. These parameters then ripple one cell per clock along the row, and each rotation cell applies them to its own skewed sample and its stored element. Column skew on the way in and deskew on the way out are both inside the row. The input and output are therefore aligned vectors with a single valid each, and rows of the same kind can be chained directly. A forgetting factor supplied on a port weights the stored state down before each update. A synchronous clear empties the stored triangle.

Top module: `givens_row`

## Requirements
- R1: After reset or a clear, every stored element is zero and out_vld is low; the first vector after that with a non-zero pivot gives all residuals 0 and out_cp 0.
- R2: Each cycle with in_vld high and clr low yields exactly one cycle of out_vld high NCOL clocks later, with results in input order; back-to-back vectors are accepted every clock.
- R3: The pivot cell forms lr = floor(lam*r / 2^FW) and r' = floor(sqrt(lr^2 + x0^2)), then c = trunc(lr*2^FW / r') and s = trunc(x0*2^FW / r'), where x0 is column 0 of in_x (bits [DW-1:0]).
- R4: When r' is zero the pivot cell uses c = 2^FW and s = 0, so each residual equals its input sample and out_cp equals in_cp.
- R5: Rotation cell k (input column k, k >= 1) forms lu = floor(lam*u / 2^FW), residual = sat(floor((c*x - s*lu) / 2^FW)) and u' = sat(floor((s*x + c*lu) / 2^FW)); residual k appears in out_x bits [(k-1)*DW +: DW].
- R6: lam is an unsigned Q1.FW forgetting factor; 2^FW means no forgetting and smaller values shrink every stored element before it is used.
- R7: The stored diagonal saturates at 2^(DW-1)-1, while c and s of that same update use the unsaturated r'.
- R8: In cycles without in_vld, no stored element changes and out_vld stays low.
- R9: A clr pulse discards every vector still in flight, and any vector presented in the same cycle, so none of them ever raises out_vld.
- R10: out_cp = sat(floor(in_cp * c / 2^FW)), delivered in the same cycle as that vector's residuals; sat clamps to signed DW bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of stored state and in-flight vectors |
| lam | input | FW+1 | Forgetting factor, unsigned Q1.FW |
| in_vld | input | 1 | Input vector valid |
| in_x | input | NCOL*DW | Sample vector, column k at bits [k*DW +: DW], column 0 is the pivot |
| in_cp | input | DW | Incoming cosine product, signed Q.FW |
| out_vld | output | 1 | Output vector valid |
| out_x | output | (NCOL-1)*DW | Rotated residuals for the next row |
| out_cp | output | DW | Outgoing cosine product |

## Verification
The row is driven with a zero pivot against an empty diagonal, which separates the degenerate identity rotation from a real one. A non-zero pivot against an empty diagonal must give a pure swap with zero residuals. Long back-to-back streams of mixed-sign samples, with unit and with reduced forgetting, show whether the cosine and sine reach each column in the right cycle and against the right stored element. A large repeated pivot drives the diagonal into saturation, which exposes whether the rotation uses the clipped or the true norm. Idle gaps and clear pulses during flight confirm that state moves only on accepted vectors.

// File: rtl/givens_pkg.sv
package givens_pkg;

   // floor(sqrt(v)) by the bit-pair method
   function automatic logic [63:0] isqrt64(input logic [63:0] v);
      logic [63:0] rem;
      logic [63:0] root;
      logic [63:0] bitv;
      rem  = v;
      root = '0;
      bitv = 64'h4000_0000_0000_0000;
      for (int i = 0; i < 32; i++) begin
         if (rem >= root + bitv) begin
            rem  = rem - (root + bitv);
            root = (root >> 1) + bitv;
         end else begin
            root = root >> 1;
         end
         bitv = bitv >> 2;
      end
      return root;
   endfunction

   // clamp to the signed range of w bits
   function automatic logic signed [63:0] sat_to(input logic signed [63:0] v, input int w);
      logic signed [63:0] hi;
      logic signed [63:0] lo;
      hi = (64'sd1 <<< (w - 1)) - 64'sd1;
      lo = -hi - 64'sd1;
      if (v > hi) return hi;
      if (v < lo) return lo;
      return v;
   endfunction

endpackage

// File: rtl/gr_delay.sv
module gr_delay #(
   parameter int W = 16,
   parameter int D = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] d_o
);
   if (D < 1) begin : g_bad_depth
      $error("gr_delay needs D >= 1");
   end

   logic [W-1:0] stg [D];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < D; k++) stg[k] <= '0;
      end else if (clr) begin
         for (int k = 0; k < D; k++) stg[k] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
      end
   end

   assign d_o = stg[D-1];
endmodule

// File: rtl/gr_angle_cell.sv
module gr_angle_cell #(
   parameter int DW = 16,
   parameter int FW = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 vld_i,
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] cp_i,
   input  logic        [FW:0]   lam_i,
   output logic                 vld_o,
   output logic signed [DW-1:0] c_o,
   output logic signed [DW-1:0] s_o,
   output logic signed [DW-1:0] cp_o,
   output logic signed [DW-1:0] diag_o
);
   import givens_pkg::*;

   localparam logic signed [63:0] ONE64 = 64'sd1 <<< FW;
   localparam logic signed [63:0] MAXP  = (64'sd1 <<< (DW - 1)) - 64'sd1;

   logic signed [DW-1:0] diag_q;
   logic signed [63:0]   lam_w, diag_w, x_w, lr, ssq, rp, rp_div;
   logic signed [63:0]   c_n, s_n, d_n, cp_n;

   assign lam_w  = 64'(lam_i);
   assign diag_w = 64'(diag_q);
   assign x_w    = 64'(x_i);
   assign lr     = (lam_w * diag_w) >>> FW;
   assign ssq    = lr * lr + x_w * x_w;
   assign rp     = $signed(isqrt64(ssq));
   assign rp_div = (rp == 64'sd0) ? 64'sd1 : rp;
   assign c_n    = (rp == 64'sd0) ? ONE64 : (lr <<< FW) / rp_div;
   assign s_n    = (rp == 64'sd0) ? 64'sd0 : (x_w <<< FW) / rp_div;
   assign d_n    = (rp > MAXP) ? MAXP : rp;
   assign cp_n   = sat_to((64'(cp_i) * c_n) >>> FW, DW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         diag_q <= '0;
         vld_o  <= 1'b0;
         c_o    <= '0;
         s_o    <= '0;
         cp_o   <= '0;
      end else if (clr) begin
         diag_q <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            diag_q <= DW'(d_n);
            c_o    <= DW'(c_n);
            s_o    <= DW'(s_n);
            cp_o   <= DW'(cp_n);
         end
      end
   end

   assign diag_o = diag_q;
endmodule

// File: rtl/gr_rot_cell.sv
module gr_rot_cell #(
   parameter int DW = 16,
   parameter int FW = 14
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 vld_i,
   input  logic signed [DW-1:0] c_i,
   input  logic signed [DW-1:0] s_i,
   input  logic signed [DW-1:0] x_i,
   input  logic        [FW:0]   lam_i,
   output logic                 vld_o,
   output logic signed [DW-1:0] c_o,
   output logic signed [DW-1:0] s_o,
   output logic signed [DW-1:0] x_o
);
   import givens_pkg::*;

   logic signed [DW-1:0] elem_q;
   logic signed [63:0]   lam_w, c_w, s_w, x_w, lu, xo_n, un_n;

   assign lam_w = 64'(lam_i);
   assign c_w   = 64'(c_i);
   assign s_w   = 64'(s_i);
   assign x_w   = 64'(x_i);
   assign lu    = (lam_w * 64'(elem_q)) >>> FW;
   assign xo_n  = sat_to((c_w * x_w - s_w * lu) >>> FW, DW);
   assign un_n  = sat_to((s_w * x_w + c_w * lu) >>> FW, DW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         elem_q <= '0;
         vld_o  <= 1'b0;
         c_o    <= '0;
         s_o    <= '0;
         x_o    <= '0;
      end else if (clr) begin
         elem_q <= '0;
         vld_o  <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            elem_q <= DW'(un_n);
            c_o    <= c_i;
            s_o    <= s_i;
            x_o    <= DW'(xo_n);
         end
      end
   end
endmodule

// File: rtl/givens_row.sv
module givens_row #(
   parameter int NCOL = 4,
   parameter int DW   = 16,
   parameter int FW   = 14
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic [FW:0]              lam,
   input  logic                     in_vld,
   input  logic [NCOL*DW-1:0]       in_x,
   input  logic [DW-1:0]            in_cp,
   output logic                     out_vld,
   output logic [(NCOL-1)*DW-1:0]   out_x,
   output logic [DW-1:0]            out_cp
);
   localparam int LAST = NCOL - 1;

   if (NCOL < 2) begin : g_bad_ncol
      $error("givens_row needs NCOL >= 2");
   end
   if (FW > DW - 2) begin : g_bad_fw
      $error("givens_row needs FW <= DW-2 so that unity fits");
   end
   if (DW > 30) begin : g_bad_dw
      $error("givens_row needs DW <= 30 for its 64-bit intermediates");
   end

   logic                 vld_ch [NCOL];
   logic signed [DW-1:0] c_ch   [NCOL];
   logic signed [DW-1:0] s_ch   [NCOL];
   logic signed [DW-1:0] bnd_diag;
   logic signed [DW-1:0] bnd_cp;

   gr_angle_cell #(.DW(DW), .FW(FW)) u_bnd (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .vld_i(in_vld & ~clr),
      .x_i(in_x[DW-1:0]),
      .cp_i(in_cp),
      .lam_i(lam),
      .vld_o(vld_ch[0]),
      .c_o(c_ch[0]),
      .s_o(s_ch[0]),
      .cp_o(bnd_cp),
      .diag_o(bnd_diag)
   );

   gr_delay #(.W(DW), .D(LAST)) u_cp_dly (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .d_i(bnd_cp), .d_o(out_cp)
   );

   for (genvar j = 1; j < NCOL; j++) begin : g_col
      logic [DW-1:0] x_skw;
      logic [DW-1:0] x_rot;

      gr_delay #(.W(DW), .D(j)) u_skew (
         .clk(clk), .rst_n(rst_n), .clr(clr),
         .d_i(in_x[j*DW +: DW]), .d_o(x_skw)
      );

      gr_rot_cell #(.DW(DW), .FW(FW)) u_rot (
         .clk(clk), .rst_n(rst_n), .clr(clr),
         .vld_i(vld_ch[j-1]),
         .c_i(c_ch[j-1]),
         .s_i(s_ch[j-1]),
         .x_i(x_skw),
         .lam_i(lam),
         .vld_o(vld_ch[j]),
         .c_o(c_ch[j]),
         .s_o(s_ch[j]),
         .x_o(x_rot)
      );

      if (j == LAST) begin : g_direct
         assign out_x[(j-1)*DW +: DW] = x_rot;
      end else begin : g_deskew
         gr_delay #(.W(DW), .D(LAST - j)) u_deskew (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .d_i(x_rot), .d_o(out_x[(j-1)*DW +: DW])
         );
      end
   end

   assign out_vld = vld_ch[LAST];
endmodule

// File: rtl/givens_row_chk.sv
module givens_row_chk #(
   parameter int NCOL = 4,
   parameter int DW   = 16,
   parameter int FW   = 14
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 clr,
   input logic                 in_vld,
   input logic                 out_vld,
   input logic signed [DW-1:0] diag,
   input logic signed [DW-1:0] c_last,
   input logic signed [DW-1:0] s_last
);
   localparam logic signed [DW-1:0] ONE  = DW'(1 << FW);
   localparam logic signed [DW-1:0] MONE = -ONE;

   logic [NCOL-1:0] vpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   vpipe <= '0;
      else if (clr) vpipe <= '0;
      else          vpipe <= {vpipe[NCOL-2:0], in_vld};
   end

   // R2, R9: one output per accepted vector, NCOL clocks later
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld == vpipe[NCOL-1]);

   // R1: a clear empties the diagonal and drops the output valid
   a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (diag == '0 && !out_vld));

   // R7: the stored diagonal never goes negative
   a_r7_diag_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
      !diag[DW-1]);

   // R3: rotation parameters reaching the last column stay within unity
   a_r3_unit_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (c_last >= 0 && c_last <= ONE && s_last >= MONE && s_last <= ONE));
endmodule

bind givens_row givens_row_chk #(.NCOL(NCOL), .DW(DW), .FW(FW)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr(clr), .in_vld(in_vld), .out_vld(out_vld),
   .diag(bnd_diag), .c_last(c_ch[NCOL-1]), .s_last(s_ch[NCOL-1])
);

// File: tb/givens_row_tb.sv
module givens_row_tb;
   localparam int NCOL = 4;
   localparam int DW   = 16;
   localparam int FW   = 14;
   localparam longint ONE = 64'sd1 <<< FW;
   localparam longint HI  = (64'sd1 <<< (DW - 1)) - 1;
   localparam longint LO  = -HI - 1;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   clr = 1'b0;
   logic [FW:0]            lam = '0;
   logic                   in_vld = 1'b0;
   logic [NCOL*DW-1:0]     in_x = '0;
   logic [DW-1:0]          in_cp = '0;
   logic                   out_vld;
   logic [(NCOL-1)*DW-1:0] out_x;
   logic [DW-1:0]          out_cp;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   longint lam_b;
   longint mr;
   longint mu [NCOL];
   longint bx  [16][NCOL];
   longint bc  [16];
   longint er  [16][NCOL-1];
   longint ecp [16];
   longint lx  [NCOL-1];
   longint lcp;

   always #4 clk = ~clk;

   givens_row #(.NCOL(NCOL), .DW(DW), .FW(FW)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr(clr), .lam(lam), .in_vld(in_vld),
      .in_x(in_x), .in_cp(in_cp), .out_vld(out_vld), .out_x(out_x), .out_cp(out_cp)
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic longint sat_b(input longint v);
      if (v > HI) return HI;
      if (v < LO) return LO;
      return v;
   endfunction

   function automatic longint isq(input longint v);
      longint g;
      g = longint'($sqrt(real'(v)));
      while (g * g > v) g--;
      while ((g + 1) * (g + 1) <= v) g++;
      return g;
   endfunction

   task automatic model_clear();
      mr = 0;
      for (int k = 0; k < NCOL; k++) mu[k] = 0;
   endtask

   task automatic set_lam(input longint v);
      lam_b = v;
      lam   = (FW+1)'(v);
   endtask

   // expected behaviour from R3..R7, R10
   task automatic model_step(input int i);
      longint lr, rp, c, s, lu;
      lr = (lam_b * mr) >>> FW;
      rp = isq(lr * lr + bx[i][0] * bx[i][0]);
      if (rp == 0) begin c = ONE; s = 0; end
      else begin c = (lr <<< FW) / rp; s = (bx[i][0] <<< FW) / rp; end
      mr = (rp > HI) ? HI : rp;
      ecp[i] = sat_b((bc[i] * c) >>> FW);
      for (int j = 1; j < NCOL; j++) begin
         lu = (lam_b * mu[j]) >>> FW;
         er[i][j-1] = sat_b((c * bx[i][j] - s * lu) >>> FW);
         mu[j]      = sat_b((s * bx[i][j] + c * lu) >>> FW);
      end
   endtask

   task automatic set_vec(input int i, input longint a, input longint b, input longint c,
                          input longint d, input longint cin);
      bx[i][0] = a; bx[i][1] = b; bx[i][2] = c; bx[i][3] = d; bc[i] = cin;
   endtask

   task automatic run_burst(input int cnt, input string tag);
      for (int i = 0; i < cnt; i++) model_step(i);
      for (int t = 0; t < cnt + NCOL; t++) begin
         @(negedge clk);
         if (t >= NCOL) begin
            chk("R2", {tag, " out_vld high"}, longint'(out_vld), 1);
            for (int k = 0; k < NCOL - 1; k++) begin
               lx[k] = longint'($signed(out_x[k*DW +: DW]));
               chk("R5", {tag, " residual"}, lx[k], er[t-NCOL][k]);
            end
            lcp = longint'($signed(out_cp));
            chk("R10", {tag, " cos product"}, lcp, ecp[t-NCOL]);
         end else begin
            chk("R2", {tag, " out_vld early"}, longint'(out_vld), 0);
         end
         if (t < cnt) begin
            in_vld = 1'b1;
            for (int k = 0; k < NCOL; k++) in_x[k*DW +: DW] = DW'(bx[t][k]);
            in_cp = DW'(bc[t]);
         end else begin
            in_vld = 1'b0;
         end
      end
      @(negedge clk);
      chk("R2", {tag, " out_vld after burst"}, longint'(out_vld), 0);
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      model_clear();
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1", "reset out_vld", longint'(out_vld), 0);
      chk("R1", "reset out_x", longint'(out_x), 0);
      chk("R1", "reset out_cp", longint'(out_cp), 0);
   endtask

   task automatic t_first_after_clear();
      pulse_clear();
      set_lam(ONE);
      set_vec(0, 1000, 200, -300, 400, ONE);
      run_burst(1, "R1 first vector");
      for (int k = 0; k < NCOL - 1; k++) chk("R1", "swap residual", lx[k], 0);
      chk("R1", "swap cos product", lcp, 0);
   endtask

   task automatic t_zero_pivot();
      pulse_clear();
      set_vec(0, 0, 500, -700, 123, ONE);
      run_burst(1, "R4 zero pivot");
      chk("R4", "residual col1", lx[0], 500);
      chk("R4", "residual col2", lx[1], -700);
      chk("R4", "residual col3", lx[2], 123);
      chk("R4", "cos product passes", lcp, ONE);
   endtask

   task automatic t_stream();
      pulse_clear();
      set_lam(ONE);
      set_vec(0, 1200, 300, -450, 900, ONE);
      set_vec(1, -800, 1000, 250, -600, ONE);
      set_vec(2, 500, -1500, 700, 40, 12000);
      set_vec(3, 2000, 0, -2500, 1800, -9000);
      set_vec(4, -300, 640, 320, -160, ONE);
      set_vec(5, 0, 0, 0, 0, ONE);
      set_vec(6, 1500, -1500, 1500, -1500, 8000);
      run_burst(7, "R3 stream");
   endtask

   task automatic t_forget();
      pulse_clear();
      set_lam(12288);
      set_vec(0, 2000, 1000, -1000, 500, ONE);
      set_vec(1, 1000, -700, 300, 900, ONE);
      set_vec(2, -1500, 400, 800, -200, ONE);
      set_vec(3, 700, 700, -700, 700, ONE);
      run_burst(4, "R6 forgetting");
      set_lam(ONE);
   endtask

   task automatic t_sat();
      pulse_clear();
      set_lam(ONE);
      set_vec(0, 30000, 1000, -2000, 3000, ONE);
      set_vec(1, 30000, -1000, 2000, 3000, ONE);
      set_vec(2, 30000, 4000, 100, -3000, ONE);
      run_burst(3, "R7 saturation");
   endtask

   task automatic t_idle();
      pulse_clear();
      set_vec(0, 900, 100, 200, 300, ONE);
      run_burst(1, "R8 before gap");
      for (int t = 0; t < 10; t++) begin
         @(negedge clk);
         in_x = {NCOL{16'h7abc}};
         chk("R8", "idle out_vld", longint'(out_vld), 0);
      end
      set_vec(0, -400, 50, -60, 70, ONE);
      run_burst(1, "R8 after gap");
   endtask

   task automatic t_clear_mid();
      pulse_clear();
      set_vec(0, 1000, 100, 100, 100, ONE);
      run_burst(1, "R9 prime");
      @(negedge clk);
      in_vld = 1'b1;
      in_x = {16'sd50, 16'sd60, 16'sd70, 16'sd800};
      @(negedge clk);
      in_vld = 1'b0;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      model_clear();
      for (int t = 0; t < NCOL + 2; t++) begin
         chk("R9", "flushed out_vld", longint'(out_vld), 0);
         @(negedge clk);
      end
      in_vld = 1'b1;
      clr = 1'b1;
      @(negedge clk);
      in_vld = 1'b0;
      clr = 1'b0;
      for (int t = 0; t < NCOL + 2; t++) begin
         chk("R9", "same-cycle clear out_vld", longint'(out_vld), 0);
         @(negedge clk);
      end
      set_vec(0, 600, 10, 20, 30, ONE);
      run_burst(1, "R9 after clear");
      for (int k = 0; k < NCOL - 1; k++) chk("R9", "state empty after clear", lx[k], 0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      model_clear();
      set_lam(ONE);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_after_clear();
      t_zero_pivot();
      t_stream();
      t_forget();
      t_sat();
      t_idle();
      t_clear_mid();
      done = 1'b1;
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end
endmodule